// File: doc/BRIEF.md
# Dual-output masked interrupt controller

This block gathers 32 level-sensitive interrupt lines into one raw level vector. From that vector it drives two processor request outputs: a normal request and a fast request. Each output has its own enable mask. Software never writes a mask directly. It sets mask bits through one register offset and clears them through another, so it can change some bits without first reading the mask.

Line 0 also carries a software-controlled bit, which is ORed with external line 0. The block does no prioritising, no vectoring and no edge capture. A request output stays high for as long as any enabled line is high.

The register interface is word addressed. A write is one cycle with `wr_en` high. Read data is combinational from `addr`. Writes to offsets that are read-only or undecoded change nothing. Reads from offsets that are write-only or undecoded return zero.

Top module: `dual_irq_mask_ctrl`

## Requirements
- R1: After reset both enable masks are zero, the software bit is zero, and both request outputs are low.
- R2: A write to word offset 2 ORs `wdata` into the normal mask. Reading offset 2 returns the normal mask.
- R3: A write to offset 3 clears every normal-mask bit that is 1 in `wdata` and leaves the other bits unchanged.
- R4: Offsets 10 and 11 set and clear the fast mask in the same way. Reading offset 10 returns the fast mask.
- R5: Offsets 1 and 9 both read the raw level. Raw bit i is input line i, except that bit 0 is external line 0 ORed with the software bit.
- R6: Offset 0 reads raw AND normal mask. Offset 8 reads raw AND fast mask.
- R7: A write to offset 4 with `wdata` bit 0 at 1 sets the software bit, and a write to offset 5 with bit 0 at 1 clears it. When bit 0 is 0, neither write has any effect. Reading offset 4 returns raw bit 0 in bit 0 and zero elsewhere.
- R8: Each request output is registered. After every rising edge it equals the OR of (raw AND its mask) as it stood before that edge.
- R9: Reads of offsets 3, 5 and 11, and of any offset that is not decoded, return zero. Writes to offsets 0, 1, 8, 9 or any undecoded offset change neither mask nor the software bit.
- R10: The two paths are independent. A line enabled only in the fast mask raises only the fast request, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 6 | Word offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| norm_req | output | 1 | Registered normal interrupt request |
| fast_req | output | 1 | Registered fast interrupt request |

## Verification
A corrupted mask bit shows at the port in two ways. It appears in the mask and status readbacks at once. It also appears on the matching request output one edge later, but only when that line is raised. A stuck or lost software bit shows in raw bit 0 and in offset 4 in the same cycle. The bench therefore raises random line patterns against random mask contents every cycle. It then reads back registers at random, so that a wrong state bit is exposed within a few cycles of being corrupted.

// File: rtl/dimc_pkg.sv
package dimc_pkg;

  // Register word offsets. The normal path sits at base 0 and the fast
  // path at base 8; within a path the layout is identical.
  localparam int unsigned PATH_STRIDE = 8;
  localparam int unsigned REL_STAT    = 0;
  localparam int unsigned REL_RAW     = 1;
  localparam int unsigned REL_EN_SET  = 2;
  localparam int unsigned REL_EN_CLR  = 3;
  localparam int unsigned OFF_SW_SET  = 4;
  localparam int unsigned OFF_SW_CLR  = 5;

  localparam int unsigned NUM_PATHS = 2;
  localparam int unsigned PATH_NORM = 0;
  localparam int unsigned PATH_FAST = 1;

  typedef struct packed {
    logic [NUM_PATHS-1:0] en_set;
    logic [NUM_PATHS-1:0] en_clr;
    logic                 sw_set;
    logic                 sw_clr;
  } wr_strobe_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STAT,
    RD_RAW,
    RD_MASK,
    RD_SWBIT
  } rd_kind_t;

  typedef struct packed {
    rd_kind_t kind;
    logic     path;
  } rd_sel_t;

endpackage

// File: rtl/dimc_decode.sv
module dimc_decode
  import dimc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output wr_strobe_t        strb,
  output rd_sel_t           rsel
);

  always_comb begin
    strb      = '0;
    rsel.kind = RD_ZERO;
    rsel.path = 1'b0;
    for (int p = 0; p < int'(NUM_PATHS); p++) begin
      if (addr == ADDR_W'(p * PATH_STRIDE + REL_STAT)) begin
        rsel.kind = RD_STAT;
        rsel.path = 1'(p);
      end
      if (addr == ADDR_W'(p * PATH_STRIDE + REL_RAW)) begin
        rsel.kind = RD_RAW;
        rsel.path = 1'(p);
      end
      if (addr == ADDR_W'(p * PATH_STRIDE + REL_EN_SET)) begin
        rsel.kind      = RD_MASK;
        rsel.path      = 1'(p);
        strb.en_set[p] = wr_en;
      end
      if (addr == ADDR_W'(p * PATH_STRIDE + REL_EN_CLR)) begin
        strb.en_clr[p] = wr_en;
      end
    end
    if (addr == ADDR_W'(OFF_SW_SET)) begin
      rsel.kind   = RD_SWBIT;
      strb.sw_set = wr_en;
    end
    if (addr == ADDR_W'(OFF_SW_CLR)) begin
      strb.sw_clr = wr_en;
    end
  end

endmodule

// File: rtl/dimc_mask.sv
module dimc_mask #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] bits_in,
  output logic [WIDTH-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (set_stb) begin
      mask <= mask | bits_in;
    end else if (clr_stb) begin
      mask <= mask & ~bits_in;
    end
  end

endmodule

// File: rtl/dimc_sw_line.sv
module dimc_sw_line (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic bit_in,
  output logic sw_bit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_bit <= 1'b0;
    end else if (set_stb && bit_in) begin
      sw_bit <= 1'b1;
    end else if (clr_stb && bit_in) begin
      sw_bit <= 1'b0;
    end
  end

endmodule

// File: rtl/dimc_out_stage.sv
module dimc_out_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] stat,
  output logic             req
);

  assign stat = level & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else begin
      req <= |stat;
    end
  end

endmodule

// File: rtl/dimc_read_mux.sv
module dimc_read_mux
  import dimc_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  rd_sel_t                         rsel,
  input  logic [WIDTH-1:0]                level,
  input  logic [NUM_PATHS-1:0][WIDTH-1:0] stat,
  input  logic [NUM_PATHS-1:0][WIDTH-1:0] mask,
  output logic [DATA_W-1:0]               rdata
);

  always_comb begin
    rdata = '0;
    unique case (rsel.kind)
      RD_STAT:  rdata = DATA_W'(stat[rsel.path]);
      RD_RAW:   rdata = DATA_W'(level);
      RD_MASK:  rdata = DATA_W'(mask[rsel.path]);
      RD_SWBIT: rdata = DATA_W'(level[0]);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/dual_irq_mask_ctrl.sv
module dual_irq_mask_ctrl
  import dimc_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               norm_req,
  output logic               fast_req
);

  wr_strobe_t                       strb;
  rd_sel_t                          rsel;
  logic                             sw_bit;
  logic [N_LINES-1:0]               lvl;
  logic [NUM_PATHS-1:0][N_LINES-1:0] en_mask;
  logic [NUM_PATHS-1:0][N_LINES-1:0] stat;
  logic [NUM_PATHS-1:0]             req;

  dimc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .strb  (strb),
    .rsel  (rsel)
  );

  dimc_sw_line u_sw (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (strb.sw_set),
    .clr_stb (strb.sw_clr),
    .bit_in  (wdata[0]),
    .sw_bit  (sw_bit)
  );

  assign lvl = irq_lines | N_LINES'(sw_bit);

  for (genvar p = 0; p < int'(NUM_PATHS); p++) begin : g_path
    dimc_mask #(.WIDTH(N_LINES)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (strb.en_set[p]),
      .clr_stb (strb.en_clr[p]),
      .bits_in (wdata[N_LINES-1:0]),
      .mask    (en_mask[p])
    );

    dimc_out_stage #(.WIDTH(N_LINES)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .level (lvl),
      .mask  (en_mask[p]),
      .stat  (stat[p]),
      .req   (req[p])
    );
  end

  dimc_read_mux #(.WIDTH(N_LINES), .DATA_W(DATA_W)) u_rd (
    .rsel  (rsel),
    .level (lvl),
    .stat  (stat),
    .mask  (en_mask),
    .rdata (rdata)
  );

  assign norm_req = req[PATH_NORM];
  assign fast_req = req[PATH_FAST];

endmodule

// File: rtl/dimc_checker.sv
module dimc_checker #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic [N_LINES-1:0] lvl,
  input logic [N_LINES-1:0] n_en,
  input logic [N_LINES-1:0] f_en,
  input logic               sw_bit,
  input logic               norm_req,
  input logic               fast_req
);

  logic wr_ro;
  assign wr_ro = wr_en && (addr == ADDR_W'(0) || addr == ADDR_W'(1) ||
                           addr == ADDR_W'(8) || addr == ADDR_W'(9) ||
                           addr == ADDR_W'(63));

  p_nset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(2)) |=> ((n_en & $past(wdata[N_LINES-1:0])) == $past(wdata[N_LINES-1:0])));

  p_nclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(3)) |=> ((n_en & $past(wdata[N_LINES-1:0])) == '0));

  p_fset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(10)) |=> ((f_en & $past(wdata[N_LINES-1:0])) == $past(wdata[N_LINES-1:0])));

  p_fclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(11)) |=> ((f_en & $past(wdata[N_LINES-1:0])) == '0));

  p_swset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4) && wdata[0]) |=> sw_bit);

  p_norm_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lvl & n_en)) |=> norm_req);

  p_norm_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(lvl & n_en)) |=> !norm_req);

  p_fast_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lvl & f_en)) |=> fast_req);

  p_wo_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(3) || addr == ADDR_W'(5) || addr == ADDR_W'(11)) |-> (rdata == '0));

  p_ro_write_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro |=> ($stable(n_en) && $stable(f_en) && $stable(sw_bit)));

endmodule

bind dual_irq_mask_ctrl dimc_checker #(
  .N_LINES (N_LINES),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .lvl      (lvl),
  .n_en     (en_mask[0]),
  .f_en     (en_mask[1]),
  .sw_bit   (sw_bit),
  .norm_req (norm_req),
  .fast_req (fast_req)
);

// File: tb/test_dual_irq_mask_ctrl.sv
`timescale 1ns/1ps
module test_dual_irq_mask_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        norm_req, fast_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_nen = '0;
  logic [31:0] m_fen = '0;
  logic        m_sw  = 1'b0;

  always #10 clk = ~clk;

  dual_irq_mask_ctrl i_dual_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .norm_req(norm_req), .fast_req(fast_req)
  );

  function automatic logic [31:0] f_level(input logic [31:0] ln);
    return ln | {31'b0, m_sw};
  endfunction

  function automatic logic [31:0] f_read(input int a, input logic [31:0] ln);
    logic [31:0] lv = f_level(ln);
    case (a)
      0:  return lv & m_nen;
      1:  return lv;
      2:  return m_nen;
      4:  return {31'b0, lv[0]};
      8:  return lv & m_fen;
      9:  return lv;
      10: return m_fen;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string f_tag(input int a);
    case (a)
      0, 8:   return "R6";
      1, 9:   return "R5";
      2:      return "R2";
      10:     return "R4";
      4:      return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input int a, input logic [31:0] d);
    case (a)
      2:  m_nen = m_nen | d;
      3:  m_nen = m_nen & ~d;
      10: m_fen = m_fen | d;
      11: m_fen = m_fen & ~d;
      4:  if (d[0]) m_sw = 1'b1;
      5:  if (d[0]) m_sw = 1'b0;
      default: ;
    endcase
  endtask

  // One cycle with optional write; checks both outputs after the edge (R8).
  task automatic cyc(input bit we, input int a, input logic [31:0] d, input logic [31:0] ln);
    logic [31:0] lv;
    logic e_n, e_f;
    @(negedge clk);
    wr_en = we; addr = 6'(a); wdata = d; irq_lines = ln;
    lv  = f_level(ln);
    e_n = |(lv & m_nen);
    e_f = |(lv & m_fen);
    @(posedge clk);
    if (we) model_write(a, d);
    #2;
    check("R8 norm_req", {31'b0, norm_req}, {31'b0, e_n});
    check("R8 fast_req", {31'b0, fast_req}, {31'b0, e_f});
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    wr_en = 1'b0; addr = 6'(a);
    #1;
    check(tag, rdata, f_read(a, irq_lines));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    irq_lines = 32'hFFFF_FFFF;
    rd(2, "R1 normal mask");
    rd(10, "R1 fast mask");
    check("R1 norm_req", {31'b0, norm_req}, 32'h0);
    check("R1 fast_req", {31'b0, fast_req}, 32'h0);
    cyc(0, 0, 0, 32'h0);
    rd(4, "R1 software bit");

    // R2/R3 set and clear normal mask
    cyc(1, 2, 32'h0000_00F0, 32'h0);
    rd(2, "R2 set");
    cyc(1, 3, 32'h0000_0030, 32'h0);
    rd(2, "R3 clear");

    // R4 fast mask
    cyc(1, 10, 32'h8000_0100, 32'h0);
    rd(10, "R4 set");
    cyc(1, 11, 32'h0000_0100, 32'h0);
    rd(10, "R4 clear");

    // R10 path independence: line 31 only in fast mask
    cyc(0, 0, 0, 32'h8000_0000);
    cyc(0, 0, 0, 32'h8000_0000);
    check("R10 fast only", {30'b0, norm_req, fast_req}, 32'h1);
    cyc(0, 0, 0, 32'h0000_0040);
    cyc(0, 0, 0, 32'h0000_0040);
    check("R10 normal only", {30'b0, norm_req, fast_req}, 32'h2);

    // R7 software line
    cyc(1, 4, 32'h0000_0002, 32'h0);
    rd(4, "R7 bit0 clear has no effect");
    cyc(1, 4, 32'h0000_0001, 32'h0);
    rd(4, "R7 set");
    rd(1, "R5 raw with soft bit");
    cyc(1, 5, 32'hFFFF_FFFE, 32'h0);
    rd(4, "R7 clear without bit0 ignored");
    cyc(1, 5, 32'h0000_0001, 32'h0);
    rd(4, "R7 cleared");

    // R9 writes to read-only and undecoded offsets
    cyc(1, 0, 32'hFFFF_FFFF, 32'h0);
    cyc(1, 1, 32'hFFFF_FFFF, 32'h0);
    cyc(1, 8, 32'hFFFF_FFFF, 32'h0);
    cyc(1, 9, 32'hFFFF_FFFF, 32'h0);
    cyc(1, 63, 32'hFFFF_FFFF, 32'h0);
    rd(2, "R9 normal mask kept");
    rd(10, "R9 fast mask kept");
    rd(4, "R9 software bit kept");
    rd(3, "R9 write-only read");
    rd(11, "R9 write-only read");
    rd(63, "R9 undecoded read");

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int a;
      bit we;
      logic [31:0] d, ln;
      a  = (($urandom % 10) == 0) ? 63 : int'($urandom % 16);
      we = ($urandom % 3) != 0;
      d  = $urandom & $urandom;
      ln = $urandom & $urandom & $urandom;
      cyc(we, a, d, ln);
      begin
        int ra;
        ra = int'($urandom % 16);
        rd(ra, f_tag(ra));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule